// File: doc/BRIEF.md
# Variable-Width Parallel CRC-32 Engine

This block keeps a running CRC-32 over a byte stream that arrives in beats of one to eight bytes. Each beat carries a 3-bit count field, and the block folds all the valid bytes of a beat into the checksum in a single clock cycle. It does this with an unrolled chain of byte-wide next-state stages, not a bit-serial loop. The generator is the usual 32-bit polynomial 0x04C11DB7. Each byte enters least-significant bit first, so the bit order is reflected. No trailing zero bytes are needed, so the result is ready as soon as the last beat has been folded.

A frame starts with a synchronous, active-low restart. The restart loads the register with either the build-time initial value or a seed supplied on the ports, and a beat presented in the same cycle is folded on top of that value. The block presents two results. The first is the raw register contents, for chaining or for inspection. The second is the finished checksum, which is the register bit-reversed and then inverted. An optional input stage registers every input before the calculation, so that the adder-free XOR network can meet a tighter clock.

Top module: `crc32_vw_engine`

## Requirements
- R1: While `restart_n` is low and `valid_i` is low, the register is loaded with `seed_i` if `seed_sel_i` is 1, or with the parameter `INIT_VAL` (default 0xFFFFFFFF) if `seed_sel_i` is 0. `rem_o` then shows that value.
- R2: When `restart_n` is low and `valid_i` is high in the same cycle, the beat is folded starting from the selected initial value, and any earlier state is discarded.
- R3: In a cycle where `valid_i` is low and `restart_n` is high, the register and both outputs keep their values, whatever is on `data_i` and `width_i`.
- R4: `width_i` holds the byte count minus one (0 means 1 byte, 7 means 8 bytes). The valid bytes occupy the lowest lanes, and lane 0 (bits 7:0) is folded first. The contents of the unused upper lanes have no effect.
- R5: A `width_i` code of `BYTES_MAX` or more is treated as a full beat of `BYTES_MAX` bytes.
- R6: `crc_o` equals `rem_o` with its 32 bits reversed, XORed with 0xFFFFFFFF. The ASCII string "123456789" started from 0xFFFFFFFF gives `crc_o` = 0xCBF43926 for every split into beats.
- R7: `rem_o` is the MSB-first remainder under polynomial 0x04C11DB7, with each byte fed bit 0 first. No final reflection or inversion is applied to it.
- R8: With `IN_REG` = 1, a beat driven before clock edge N shows on the outputs after edge N+1. With `IN_REG` = 0, it shows after edge N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| restart_n | input | 1 | Synchronous active-low frame restart; loads the initial value |
| valid_i | input | 1 | The beat on `data_i` is to be folded |
| width_i | input | 3 | Valid byte count minus one |
| data_i | input | BYTES_MAX*8 | Beat data, lane 0 in bits 7:0 |
| seed_sel_i | input | 1 | 1 selects `seed_i` as the initial value on restart |
| seed_i | input | 32 | Run-time initial value |
| crc_o | output | 32 | Finished checksum (reflected and inverted) |
| rem_o | output | 32 | Raw running remainder |

## Verification
The check string "123456789" is fed in every beat split from one to eight bytes per beat, on a 4-byte registered instance and an 8-byte unregistered instance. A wrong lane order or a wrong partial-beat selection changes the fixed answer for some of those splits and not for others. Random messages with random seeds and random beat sizes are compared against an LSB-first model that uses the reflected polynomial. Because every beat carries random junk in its unused upper lanes, the lane masking is tested as well. Directed cases then separate the remaining behaviours: a restart with and without a same-cycle beat, idle cycles with toggling data, a width code above the bus size, and the one-edge difference in latency between the two input-stage variants.

// File: rtl/crc32_vw_pkg.sv
// Shared constants and helpers for the variable-width CRC-32 engine.
// Assumes a 32-bit register with MSB-first update and reflected byte input.
package crc32_vw_pkg;

    localparam int unsigned CRC_W = 32;
    localparam logic [CRC_W-1:0] GEN_POLY  = 32'h04C11DB7;
    localparam logic [CRC_W-1:0] FINAL_XOR = 32'hFFFFFFFF;

    // Reverse the bit order of a 32-bit word.
    function automatic logic [CRC_W-1:0] rev32(input logic [CRC_W-1:0] v);
        logic [CRC_W-1:0] r;
        for (int i = 0; i < CRC_W; i++) begin
            r[i] = v[CRC_W-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/crc32_byte_step.sv
// Combinational fold of one byte into a CRC-32 register.
// The byte enters bit 0 first (reflected input); the register shifts toward the MSB.
module crc32_byte_step
    import crc32_vw_pkg::*;
(
    input  logic [CRC_W-1:0] crc_in,
    input  logic [7:0]       byte_in,
    output logic [CRC_W-1:0] crc_out
);

    logic [CRC_W-1:0] acc;
    logic             fb;

    // Unrolled eight-bit division step.
    always_comb begin
        acc = crc_in;
        fb  = 1'b0;
        for (int i = 0; i < 8; i++) begin
            fb  = acc[CRC_W-1] ^ byte_in[i];
            acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? GEN_POLY : '0);
        end
        crc_out = acc;
    end

endmodule

// File: rtl/crc32_fold_chain.sv
// Chain of byte steps across all lanes of a beat; selects the tap that matches
// the byte count. Lane 0 is folded first. Codes beyond the bus select the full beat.
module crc32_fold_chain
    import crc32_vw_pkg::*;
#(
    parameter int unsigned BYTES_MAX = 4
) (
    input  logic [CRC_W-1:0]       crc_in,
    input  logic [BYTES_MAX*8-1:0] data,
    input  logic [2:0]             count_code,
    output logic [CRC_W-1:0]       crc_out
);

    logic [CRC_W-1:0] stage [0:BYTES_MAX];

    assign stage[0] = crc_in;

    // One byte step per lane, each fed by the previous lane's result.
    for (genvar g = 0; g < BYTES_MAX; g++) begin : g_lane
        crc32_byte_step u_step (
            .crc_in (stage[g]),
            .byte_in(data[g*8 +: 8]),
            .crc_out(stage[g+1])
        );
    end

    // Pick the chain tap after the last valid byte, clamped to the bus size.
    always_comb begin
        crc_out = stage[1];
        for (int i = 1; i < BYTES_MAX; i++) begin
            if (int'(count_code) >= i) begin
                crc_out = stage[i+1];
            end
        end
    end

endmodule

// File: rtl/crc32_in_stage.sv
// Optional input register stage. It also resolves which initial value a restart uses.
// With IN_REG=0 every signal passes straight through.
module crc32_in_stage
    import crc32_vw_pkg::*;
#(
    parameter int unsigned      BYTES_MAX = 4,
    parameter bit               IN_REG    = 1'b1,
    parameter logic [CRC_W-1:0] INIT_VAL  = 32'hFFFFFFFF
) (
    input  logic                   clk,
    input  logic                   restart_n,
    input  logic                   valid_i,
    input  logic [2:0]             width_i,
    input  logic [BYTES_MAX*8-1:0] data_i,
    input  logic                   seed_sel_i,
    input  logic [CRC_W-1:0]       seed_i,
    output logic                   eff_restart,
    output logic                   eff_valid,
    output logic [2:0]             eff_width,
    output logic [BYTES_MAX*8-1:0] eff_data,
    output logic [CRC_W-1:0]       eff_init
);

    logic [CRC_W-1:0] init_pick;

    // Choose the initial value for this cycle.
    assign init_pick = seed_sel_i ? seed_i : INIT_VAL;

    if (IN_REG) begin : g_reg
        // Capture every input one cycle ahead of the CRC register.
        always_ff @(posedge clk) begin
            eff_restart <= ~restart_n;
            eff_valid   <= valid_i;
            eff_width   <= width_i;
            eff_data    <= data_i;
            eff_init    <= init_pick;
        end
    end else begin : g_pass
        assign eff_restart = ~restart_n;
        assign eff_valid   = valid_i;
        assign eff_width   = width_i;
        assign eff_data    = data_i;
        assign eff_init    = init_pick;
    end

endmodule

// File: rtl/crc32_vw_engine.sv
// Variable-width parallel CRC-32 engine: folds 1..BYTES_MAX bytes per beat in one cycle.
// Assumes the valid bytes sit in the low lanes. Restart is synchronous and active low,
// and a beat presented with the restart is folded on top of the initial value.
module crc32_vw_engine
    import crc32_vw_pkg::*;
#(
    parameter int unsigned      BYTES_MAX = 4,
    parameter bit               IN_REG    = 1'b1,
    parameter logic [CRC_W-1:0] INIT_VAL  = 32'hFFFFFFFF
) (
    input  logic                   clk,
    input  logic                   restart_n,
    input  logic                   valid_i,
    input  logic [2:0]             width_i,
    input  logic [BYTES_MAX*8-1:0] data_i,
    input  logic                   seed_sel_i,
    input  logic [CRC_W-1:0]       seed_i,
    output logic [CRC_W-1:0]       crc_o,
    output logic [CRC_W-1:0]       rem_o
);

    localparam int unsigned DW = BYTES_MAX * 8;

    logic             eff_restart;
    logic             eff_valid;
    logic [2:0]       eff_width;
    logic [DW-1:0]    eff_data;
    logic [CRC_W-1:0] eff_init;
    logic [CRC_W-1:0] fold_base;
    logic [CRC_W-1:0] fold_next;
    logic [CRC_W-1:0] crc_q;

    crc32_in_stage #(
        .BYTES_MAX(BYTES_MAX),
        .IN_REG   (IN_REG),
        .INIT_VAL (INIT_VAL)
    ) u_in (
        .clk        (clk),
        .restart_n  (restart_n),
        .valid_i    (valid_i),
        .width_i    (width_i),
        .data_i     (data_i),
        .seed_sel_i (seed_sel_i),
        .seed_i     (seed_i),
        .eff_restart(eff_restart),
        .eff_valid  (eff_valid),
        .eff_width  (eff_width),
        .eff_data   (eff_data),
        .eff_init   (eff_init)
    );

    // A restart folds from the initial value; otherwise fold from the running state.
    assign fold_base = eff_restart ? eff_init : crc_q;

    crc32_fold_chain #(
        .BYTES_MAX(BYTES_MAX)
    ) u_fold (
        .crc_in    (fold_base),
        .data      (eff_data),
        .count_code(eff_width),
        .crc_out   (fold_next)
    );

    // CRC register: load on restart, advance on valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (eff_valid) begin
            crc_q <= fold_next;
        end else if (eff_restart) begin
            crc_q <= eff_init;
        end
    end

    // Raw remainder and the reflected, inverted final checksum.
    assign rem_o = crc_q;
    assign crc_o = rev32(crc_q) ^ FINAL_XOR;

endmodule

// File: rtl/crc32_vw_engine_chk.sv
// Assertion checker for crc32_vw_engine, attached with bind.
// Properties become active once a restart has reached the CRC register.
module crc32_vw_engine_chk #(
    parameter bit IN_REG = 1'b1
) (
    input logic        clk,
    input logic        restart_n,
    input logic        valid_i,
    input logic        eff_restart,
    input logic        eff_valid,
    input logic [31:0] eff_init,
    input logic [31:0] rem_o
);

    logic started = 1'b0;

    // Mark that the register has been given a defined value.
    always_ff @(posedge clk) begin
        started <= started | eff_restart;
    end

    assert_restart_load_R1: assert property (@(posedge clk) disable iff (!started)
        (eff_restart && !eff_valid) |=> (rem_o == $past(eff_init)));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!started)
        (!eff_restart && !eff_valid) |=> $stable(rem_o));

    assert_valid_delay_R8: assert property (@(posedge clk) disable iff (!started)
        (IN_REG != 0) |-> (eff_valid == $past(valid_i)));

    assert_restart_delay_R8: assert property (@(posedge clk) disable iff (!started)
        (IN_REG != 0) |-> (eff_restart == $past(!restart_n)));

endmodule

bind crc32_vw_engine crc32_vw_engine_chk #(.IN_REG(IN_REG)) u_chk (
    .clk        (clk),
    .restart_n  (restart_n),
    .valid_i    (valid_i),
    .eff_restart(eff_restart),
    .eff_valid  (eff_valid),
    .eff_init   (eff_init),
    .rem_o      (rem_o)
);

// File: tb/crc32_vw_engine_tb.sv
// Directed bench: u_dut is 4 bytes wide with the input stage; u_dut8 is 8 bytes wide without it.
module crc32_vw_engine_tb;

    logic        clk = 1'b0;
    logic        restart_n = 1'b0;
    logic        seed_sel = 1'b0;
    logic [31:0] seed_val = 32'h0;
    logic        valid_a = 1'b0;
    logic [2:0]  width_a = 3'd0;
    logic [31:0] data_a = 32'h0;
    logic        valid_b = 1'b0;
    logic [2:0]  width_b = 3'd0;
    logic [63:0] data_b = 64'h0;
    logic [31:0] crc_a, rem_a, crc_b, rem_b;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] msg [0:63];

    always #2 clk = ~clk;

    crc32_vw_engine #(.BYTES_MAX(4), .IN_REG(1'b1)) u_dut (
        .clk(clk), .restart_n(restart_n), .valid_i(valid_a), .width_i(width_a),
        .data_i(data_a), .seed_sel_i(seed_sel), .seed_i(seed_val),
        .crc_o(crc_a), .rem_o(rem_a)
    );

    crc32_vw_engine #(.BYTES_MAX(8), .IN_REG(1'b0)) u_dut8 (
        .clk(clk), .restart_n(restart_n), .valid_i(valid_b), .width_i(width_b),
        .data_i(data_b), .seed_sel_i(seed_sel), .seed_i(seed_val),
        .crc_o(crc_b), .rem_o(rem_b)
    );

    // Reference model: LSB-first register with the reflected polynomial.
    function automatic logic [31:0] m_rev(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

    function automatic logic [31:0] m_step(input logic [31:0] r, input logic [7:0] b);
        logic [31:0] x;
        x = r ^ {24'h0, b};
        for (int i = 0; i < 8; i++) x = x[0] ? ((x >> 1) ^ 32'hEDB88320) : (x >> 1);
        return x;
    endfunction

    // Expected raw remainder after folding msg[0..len-1] from seed s.
    function automatic logic [31:0] m_rem(input logic [31:0] s, input int len);
        logic [31:0] r;
        r = m_rev(s);
        for (int i = 0; i < len; i++) r = m_step(r, msg[i]);
        return m_rev(r);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_restart(input logic sel, input logic [31:0] sv);
        @(negedge clk);
        restart_n = 1'b0; seed_sel = sel; seed_val = sv; valid_a = 1'b0; valid_b = 1'b0;
        @(negedge clk);
        restart_n = 1'b1;
        @(negedge clk);
    endtask

    // Feed msg[0..len-1] in beats of k bytes to one DUT, junk in the upper lanes.
    task automatic feed(input int dut, input int len, input int k, input bit restart_first);
        for (int p = 0; p < len; p += k) begin
            int n = (len - p < k) ? (len - p) : k;
            logic [63:0] w = {$urandom(), $urandom()};
            for (int j = 0; j < n; j++) w[j*8 +: 8] = msg[p+j];
            @(negedge clk);
            restart_n = !(restart_first && p == 0);
            if (dut == 0) begin
                valid_a = 1'b1; width_a = 3'(n - 1); data_a = w[31:0];
            end else begin
                valid_b = 1'b1; width_b = 3'(n - 1); data_b = w;
            end
        end
        @(negedge clk);
        restart_n = 1'b1; valid_a = 1'b0; valid_b = 1'b0;
        @(negedge clk);
    endtask

    task automatic load_check_string();
        for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
    endtask

    // R1, R6: restart with the parameter value and with a run-time seed.
    task automatic test_restart_values();
        do_restart(1'b0, 32'h0);
        check("R1 param init A", rem_a, 32'hFFFFFFFF);
        check("R1 param init B", rem_b, 32'hFFFFFFFF);
        check("R6 crc of init A", crc_a, 32'h00000000);
        do_restart(1'b1, 32'h12345678);
        check("R1 seed init A", rem_a, 32'h12345678);
        check("R1 seed init B", rem_b, 32'h12345678);
        check("R6 crc of seed B", crc_b, m_rev(32'h12345678) ^ 32'hFFFFFFFF);
    endtask

    // R4, R6: check string with every beat split.
    task automatic test_check_string();
        load_check_string();
        for (int k = 1; k <= 8; k++) begin
            do_restart(1'b0, 32'h0);
            feed(1, 9, k, 1'b0);
            check($sformatf("R6 check string B k=%0d", k), crc_b, 32'hCBF43926);
            if (k <= 4) begin
                feed(0, 9, k, 1'b0);
                check($sformatf("R4 check string A k=%0d", k), crc_a, 32'hCBF43926);
            end
        end
    endtask

    // R7: random messages, seeds and beat sizes against the model.
    task automatic test_random();
        for (int t = 0; t < 12; t++) begin
            int len = 1 + int'($urandom_range(0, 39));
            logic [31:0] sv = $urandom();
            for (int i = 0; i < len; i++) msg[i] = 8'($urandom());
            do_restart(1'b1, sv);
            feed(0, len, 1 + int'($urandom_range(0, 3)), 1'b0);
            feed(1, len, 1 + int'($urandom_range(0, 7)), 1'b0);
            check("R7 random rem A", rem_a, m_rem(sv, len));
            check("R7 random rem B", rem_b, m_rem(sv, len));
            check("R6 random crc B", crc_b, m_rev(m_rem(sv, len)) ^ 32'hFFFFFFFF);
        end
    endtask

    // R3: idle cycles with toggling data and width leave outputs unchanged.
    task automatic test_hold();
        logic [31:0] ra, rb, ca;
        for (int i = 0; i < 6; i++) msg[i] = 8'($urandom());
        do_restart(1'b0, 32'h0);
        feed(0, 6, 3, 1'b0);
        feed(1, 6, 5, 1'b0);
        ra = rem_a; rb = rem_b; ca = crc_a;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            data_a = $urandom(); data_b = {$urandom(), $urandom()};
            width_a = 3'($urandom()); width_b = 3'($urandom());
        end
        @(negedge clk);
        @(negedge clk);
        check("R3 hold rem A", rem_a, ra);
        check("R3 hold crc A", crc_a, ca);
        check("R3 hold rem B", rem_b, rb);
    endtask

    // R2: restart with a same-cycle beat discards the prior state.
    task automatic test_restart_with_beat();
        for (int i = 0; i < 7; i++) msg[i] = 8'($urandom());
        do_restart(1'b0, 32'h0);
        feed(0, 7, 2, 1'b0);
        feed(1, 7, 4, 1'b0);
        for (int i = 0; i < 10; i++) msg[i] = 8'($urandom());
        seed_sel = 1'b1; seed_val = 32'hA5A55A5A;
        feed(0, 10, 4, 1'b1);
        check("R2 restart+beat A", rem_a, m_rem(32'hA5A55A5A, 10));
        feed(1, 10, 8, 1'b1);
        check("R2 restart+beat B", rem_b, m_rem(32'hA5A55A5A, 10));
    endtask

    // R5: width code above the bus size on the 4-byte instance folds 4 bytes.
    task automatic test_clamp();
        for (int i = 0; i < 4; i++) msg[i] = 8'($urandom());
        do_restart(1'b0, 32'h0);
        @(negedge clk);
        valid_a = 1'b1; width_a = 3'd7; data_a = {msg[3], msg[2], msg[1], msg[0]};
        @(negedge clk);
        valid_a = 1'b0;
        @(negedge clk);
        check("R5 width clamp A", rem_a, m_rem(32'hFFFFFFFF, 4));
    endtask

    // R8: one edge of latency without the stage, two with it.
    task automatic test_latency();
        msg[0] = 8'h5C;
        do_restart(1'b0, 32'h0);
        @(negedge clk);
        valid_a = 1'b1; width_a = 3'd0; data_a = 32'h0000005C;
        valid_b = 1'b1; width_b = 3'd0; data_b = 64'h5C;
        @(negedge clk);
        valid_a = 1'b0; valid_b = 1'b0;
        check("R8 unstaged after one edge", rem_b, m_rem(32'hFFFFFFFF, 1));
        check("R8 staged not yet updated", rem_a, 32'hFFFFFFFF);
        @(negedge clk);
        check("R8 staged after two edges", rem_a, m_rem(32'hFFFFFFFF, 1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_restart_values();
        test_check_string();
        test_random();
        test_hold();
        test_restart_with_beat();
        test_clamp();
        test_latency();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1..R8 run hung actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule